// File: doc/BRIEF.md
# FM Operator Log-Domain Output Stage

This block produces the signed sample of one FM synthesis operator from three values: the operator's 10-bit phase, a signed phase-modulation offset and a 10-bit envelope attenuation. It never multiplies. The modulated phase addresses a quarter-wave table that holds the negated base-2 logarithm of sine. The envelope attenuation, scaled to the same fixed-point grid, is added to that value. A second table then turns the fractional part of the total back to linear amplitude. A right shift by the integer part finishes the conversion, and the phase's top bit supplies the sign.

Both tables are read-only contents. They are computed from real-valued formulas when the design is elaborated. The path is a two-stage pipeline and accepts one operand set every cycle. Each valid input yields one valid sample exactly two cycles later.

Top module: `fm_op_out`

## Requirements
- R1: The effective phase is (phase_i + pm_ofs_i) mod 1024, and it is formed before any table access. pm_ofs_i is a 10-bit two's-complement value.
- R2: Bit 8 of the effective phase selects the table index. When bit 8 is 0 the index is bits 7:0. When bit 8 is 1 the index is the bitwise inverse of bits 7:0. With envelope 0, effective phase 0x100 therefore gives +8168.
- R3: Log-sine table entry n (n = 0..255, 12 bits, 4.8 fixed point) equals round(256 * -log2(sin((2n+1)/512 * pi/2))).
- R4: Total attenuation is the log-sine entry plus env_i shifted left by 2. It is a 13-bit value in 5.8 fixed point.
- R5: The magnitude is power table entry f shifted left by 2, then shifted right by the integer part i. Here f is attenuation bits 7:0 and i is bits 12:8. Entry n (11 bits) equals round(2048 * 2^(-(n+1)/256)).
- R6: When the integer part is 13 or more, the magnitude is 0. Any env_i of 0x340 or above therefore gives a sample of 0.
- R7: When bit 9 of the effective phase is 1, sample_o is the 14-bit two's-complement negation of the magnitude. Otherwise it is the magnitude. Effective phase 0x300 with envelope 0 gives -8168.
- R8: out_valid_o is in_valid_i delayed by exactly 2 cycles, and sample_o belongs to the input presented two cycles earlier. In reset, out_valid_o is 0 and sample_o is 0.
- R9: A new operand set is accepted every cycle with in_valid_i high. No output is produced for cycles with in_valid_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Operand set present |
| phase_i | input | 10 | Operator phase, full cycle = 1024 |
| pm_ofs_i | input | 10 | Signed phase-modulation offset |
| env_i | input | 10 | Envelope attenuation, 4.6 fixed point |
| out_valid_o | output | 1 | Sample present |
| sample_o | output | 14 | Signed operator sample |

## Verification
The assertions need in_valid_i to be a defined level on every clock edge after reset. They place no limit on phase, offset or envelope, because every 10-bit code is legal. The stimulus keeps to this: it drives in_valid_i from a single task at the falling edge, holds it low throughout reset, and inserts idle cycles between bursts. Operand values are random across the full range and are mixed with directed values at the mirror point, at the sign boundary, at the wrap point and at the mute threshold 0x340.

// File: rtl/fm_op_out.sv
module fm_op_out #(
  parameter int PH_W  = 10,
  parameter int ENV_W = 10,
  parameter int OUT_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid_i,
  input  logic [PH_W-1:0]         phase_i,
  input  logic [PH_W-1:0]         pm_ofs_i,
  input  logic [ENV_W-1:0]        env_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam int IDX_W = PH_W - 2;
  localparam int ROWS  = 1 << IDX_W;
  localparam int LS_W  = 12;
  localparam int PW_W  = 11;
  localparam int AT_W  = 13;
  localparam int MAG_W = OUT_W - 1;
  localparam int SH_W  = AT_W - 8;

  function automatic logic [LS_W-1:0] logsin_entry(input int n);
    real x;
    x = (2.0 * n + 1.0) / 512.0 * (3.14159265358979 / 2.0);
    return LS_W'($rtoi(-$ln($sin(x)) / $ln(2.0) * 256.0 + 0.5));
  endfunction

  function automatic logic [PW_W-1:0] pow_entry(input int n);
    return PW_W'($rtoi(2048.0 * (2.0 ** (-(n + 1.0) / 256.0)) + 0.5));
  endfunction

  logic [LS_W-1:0] ls_rom [ROWS];
  logic [PW_W-1:0] pw_rom [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_rom
    localparam logic [LS_W-1:0] LS = logsin_entry(g);
    localparam logic [PW_W-1:0] PW = pow_entry(g);
    assign ls_rom[g] = LS;
    assign pw_rom[g] = PW;
  end

  logic [PH_W-1:0]  ph_eff;
  logic [IDX_W-1:0] idx;
  logic [AT_W-1:0]  atten;

  assign ph_eff = phase_i + pm_ofs_i;
  assign idx    = ph_eff[PH_W-2] ? ~ph_eff[IDX_W-1:0] : ph_eff[IDX_W-1:0];
  assign atten  = AT_W'(ls_rom[idx]) + AT_W'({env_i, 2'b00});

  logic            s1_v, s1_neg;
  logic [SH_W-1:0] s1_sh;
  logic [PW_W-1:0] s1_man;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_neg <= 1'b0;
      s1_sh  <= '0;
      s1_man <= '0;
    end else begin
      s1_v   <= in_valid_i;
      s1_neg <= ph_eff[PH_W-1];
      s1_sh  <= atten[AT_W-1:8];
      s1_man <= pw_rom[atten[7:0]];
    end
  end

  logic [MAG_W-1:0] mag;
  assign mag = (s1_sh >= SH_W'(13)) ? '0 : ({s1_man, 2'b00} >> s1_sh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      sample_o    <= '0;
    end else begin
      out_valid_o <= s1_v;
      sample_o    <= s1_neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
  end

  // R8: output strobe follows the stage-one strobe by one cycle
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o == $past(s1_v));

  // R6: envelope at or past the mute threshold silences the sample two cycles later
  assert_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && env_i >= ENV_W'(10'h340)) |=> ##1 (sample_o == '0));

  // R7: a positive half-wave never produces a negative sample
  assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !s1_neg) |=> !sample_o[OUT_W-1]);

  // R5: magnitude never exceeds the largest table value shifted by 2
  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (sample_o <= 14'sd8168 && sample_o >= -14'sd8168));

  // R9: an idle input cycle yields an idle output cycle
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ##1 !out_valid_o);
endmodule

// File: tb/test_fm_op_out.sv
module test_fm_op_out;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [9:0] phase = 0, ofs = 0, env = 0;
  logic out_valid;
  logic signed [13:0] sample;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fm_op_out i_fm_op_out (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .phase_i(phase),
    .pm_ofs_i(ofs), .env_i(env), .out_valid_o(out_valid), .sample_o(sample)
  );

  typedef struct { logic signed [13:0] val; string tag; } item_t;
  item_t q[$];
  int ls_t [256];
  int pw_t [256];

  initial begin
    for (int n = 0; n < 256; n++) begin
      real x;
      x = (2.0 * n + 1.0) / 512.0 * (3.14159265358979 / 2.0);
      ls_t[n] = $rtoi(-$ln($sin(x)) / $ln(2.0) * 256.0 + 0.5);
      pw_t[n] = $rtoi(2048.0 * (2.0 ** (-(n + 1.0) / 256.0)) + 0.5);
    end
  end

  function automatic int model(int p, int o, int e);
    int ph, ix, at, ip, m;
    ph = (p + o) % 1024;
    ix = (ph & 256) ? (255 - (ph & 255)) : (ph & 255);
    at = ls_t[ix] + e * 4;
    ip = at / 256;
    m  = (ip >= 13) ? 0 : ((pw_t[at % 256] * 4) >> ip);
    return (ph & 512) ? -m : m;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int p, int o, int e, string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1; phase = 10'(p); ofs = 10'(o); env = 10'(e);
    it.val = 14'(model(p, o, e)); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) check(0, "R9 unexpected output", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        check(sample === it.val, it.tag, sample, it.val);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid === 0, "R8 reset valid", out_valid, 0);
    check(sample === 0, "R8 reset sample", sample, 0);
    rst_n = 1;
    idle(2);
    drive(10'h100, 0, 0, "R2 mirror peak");
    drive(10'h300, 0, 0, "R7 negative peak");
    check(q[0].val == 8168, "R5 peak value", q[0].val, 8168);
    check(q[1].val == -8168, "R7 negative peak value", q[1].val, -8168);
    drive(0, 0, 0, "R3 first entry");
    drive(1000, 100, 0, "R1 wrap sum");
    drive(5, 10'h3FB, 0, "R1 negative offset");
    drive(10'h0FF, 0, 0, "R2 last first-quarter");
    drive(10'h140, 0, 10'h080, "R4 envelope added");
    drive(10'h100, 0, 10'h33F, "R6 just below mute");
    drive(10'h100, 0, 10'h340, "R6 mute threshold");
    drive(10'h300, 0, 10'h3FF, "R6 mute full");
    drive(10'h2C0, 0, 10'h020, "R7 negative half");
    idle(3);
    check(q.size() == 0, "R8 drained", q.size(), 0);
    for (int b = 0; b < 40; b++) begin
      for (int k = 0; k < 50; k++)
        drive($urandom % 1024, $urandom % 1024, $urandom % 1024, "R5 random");
      idle(b % 3);
    end
    idle(4);
    check(q.size() == 0, "R9 all outputs seen", q.size(), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) check(0, "R8 watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule